// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter that advances once per period of a selectable prescaler tap. Its control/status register holds an overflow flag, a mode select, a timer enable and a 3-bit clock select. A 17-bit prescaler runs freely from the input clock, and the clock select chooses which of its eight taps paces the counter.

In interval mode, a counter wrap from 0xFF to 0x00 sets the overflow flag, and an interrupt request follows the flag while an external enable input allows it. In watchdog mode, the same wrap drives a reset request that is one clock wide. On the following edge every register inside the block, the prescaler included, returns to its reset value.

A host reaches the block through a synchronous register interface. It has separate write strobes for the counter and for the control/status register, a read strobe for the control/status register, and both registers are visible at all times on read-data outputs. The overflow flag cannot be cleared by accident. The clearing write must come after a read that saw the flag set.

Top module: `wdog_itmr`

## Requirements
- R1: After `rst_n` is low at a clock edge, `cnt_q` is 0x00, `ctl_q` is 0x00, and `irq_req` and `rst_req` are 0.
- R2: With the timer enabled, the counter advances by exactly one for each full divisor period of input clocks. The divisor is chosen by `ctl_q[2:0]`: 0 gives /2, 1 gives /64, 2 gives /128, 3 gives /512, 4 gives /2048, 5 gives /8192, 6 gives /32768 and 7 gives /131072.
- R3: While the enable bit `ctl_q[5]` is 0, the counter is held at 0x00 and counter writes are ignored.
- R4: A counter write (`host_wr_cnt`) while enabled loads `host_wdata` at that edge. The load takes priority over a count in the same cycle.
- R5: A count that takes the counter from 0xFF to 0x00 sets the overflow flag `ctl_q[7]`. The flag is never set otherwise.
- R6: The overflow flag clears only on a control write with bit 7 at 0 that follows a control read (`host_rd_ctl`) which saw the flag at 1. Writing 1 to bit 7 neither sets nor clears the flag.
- R7: A control write with the enable bit (bit 5) at 0 clears the overflow flag, with or without a prior read.
- R8: In interval mode (`ctl_q[6]` = 0), `irq_req` equals the overflow flag ANDed with `irq_en`. In watchdog mode, `irq_req` is 0.
- R9: In watchdog mode (`ctl_q[6]` = 1), an overflow raises `rst_req` for exactly one clock. While that pulse is high the flag reads 1. On the next edge `ctl_q` and `cnt_q` return to 0x00.
- R10: Control writes store bit 6 (mode), bit 5 (enable) and bits 2..0 (select). Bits 4 and 3 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_cnt | input | 1 | Counter write strobe |
| host_wr_ctl | input | 1 | Control/status write strobe |
| host_rd_ctl | input | 1 | Control/status read strobe |
| host_wdata | input | 8 | Host write data |
| irq_en | input | 1 | Interrupt enable from the system |
| cnt_q | output | 8 | Counter value |
| ctl_q | output | 8 | Control/status register value |
| irq_req | output | 1 | Interval-mode interrupt request |
| rst_req | output | 1 | Watchdog reset request, one clock wide |

## Verification
The watchdog reset pulse is the hardest case to reach. A pure count-up from reset would need 256 prescaler periods to get there. The stimulus instead selects the /2 tap, switches on watchdog mode and preloads the counter with 0xFD, so the wrap arrives within a few cycles. The bench then polls each cycle, catches the single-cycle pulse, and checks the flag during the pulse and the cleared registers on the cycle after.

The prescaler phase is unknown to the bench, so each divisor is checked over a window that is an exact multiple of its period. Every such window contains the same number of counts whatever the phase.

// File: rtl/wdog_pkg.sv
// Package: shared widths, register bit positions and the tap table
// for the watchdog / interval timer.
// Assumes: every tap position returned by tap_pos fits inside PRE_W.
package wdog_pkg;
    localparam int CNT_W  = 8;
    localparam int PRE_W  = 17;
    localparam int SEL_W  = 3;
    localparam int NTAP   = 1 << SEL_W;

    // Control/status bit positions
    localparam int BIT_OVF  = 7;
    localparam int BIT_MODE = 6;
    localparam int BIT_EN   = 5;

    // log2 of the divisor for each clock select code
    function automatic int tap_pos(input int code);
        case (code)
            0: return 1;
            1: return 6;
            2: return 7;
            3: return 9;
            4: return 11;
            5: return 13;
            6: return 15;
            default: return 17;
        endcase
    endfunction
endpackage

// File: rtl/wdog_prescaler.sv
// Module: free-running prescaler with tap selection.
// Emits one-cycle tick pulses on the rising edge of the selected tap.
// The edge is decoded from the count value itself, so changing the
// select never produces extra ticks.
// Assumes: srst_n is synchronous and active low.
module wdog_prescaler #(
    parameter int PRE_W = wdog_pkg::PRE_W,
    parameter int SEL_W = wdog_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NTAP = 1 << SEL_W;

    logic [PRE_W-1:0] pcnt;
    logic [NTAP-1:0]  tap_hit;

    // Free-running prescale counter
    always_ff @(posedge clk) begin
        if (!srst_n) pcnt <= '0;
        else         pcnt <= pcnt + 1'b1;
    end

    // Rising-edge decode of each tap: tap bit just became 1, all lower bits are 0
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        localparam int K = wdog_pkg::tap_pos(i);
        if (K == 1) begin : g_lsb
            assign tap_hit[i] = pcnt[0];
        end else begin : g_upper
            assign tap_hit[i] = pcnt[K-1] & ~(|pcnt[K-2:0]);
        end
    end

    // Select the active tap
    assign tick = tap_hit[sel];
endmodule

// File: rtl/wdog_counter.sv
// Module: timer count register.
// Holds at zero while disabled. Otherwise a host load takes priority
// over a tick, and a tick increments the count.
// Flags a wrap when a tick takes the all-ones value to zero.
// Assumes: tick is a single-cycle pulse.
module wdog_counter #(
    parameter int CNT_W = wdog_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Wrap event: a real count from the maximum value
    assign wrap = en & tick & ~load & (cnt == CNT_MAX);

    // Counter update: clear while disabled, load first, then count
    always_ff @(posedge clk) begin
        if (!srst_n || !en) cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (tick)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdog_csr.sv
// Module: control/status register.
// Holds the mode, enable and select fields, plus the overflow flag
// and its read-arm latch.
// The flag clears on a write of 0 to its bit only after a read has
// seen it set. Disabling the timer clears the flag unconditionally.
// Assumes: wrap is a single-cycle pulse from the counter.
module wdog_csr #(
    parameter int DATA_W = wdog_pkg::CNT_W,
    parameter int SEL_W  = wdog_pkg::SEL_W
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wrap,
    output logic              ovf,
    output logic              mode,
    output logic              en,
    output logic [SEL_W-1:0]  sel
);
    import wdog_pkg::*;

    logic armed;

    // Writable fields
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            mode <= 1'b0;
            en   <= 1'b0;
            sel  <= '0;
        end else if (wr) begin
            mode <= wdata[BIT_MODE];
            en   <= wdata[BIT_EN];
            sel  <= wdata[SEL_W-1:0];
        end
    end

    // Overflow flag and read-arm: disable clears, wrap sets, armed write-0 clears
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            ovf   <= 1'b0;
            armed <= 1'b0;
        end else if (wr && !wdata[BIT_EN]) begin
            ovf   <= 1'b0;
            armed <= 1'b0;
        end else if (wrap) begin
            ovf   <= 1'b1;
        end else if (wr && armed && !wdata[BIT_OVF]) begin
            ovf   <= 1'b0;
            armed <= 1'b0;
        end else if (rd && ovf) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/wdog_itmr.sv
// Module: watchdog / interval timer top.
// Joins the prescaler, counter and control register. It produces the
// interval interrupt request and a one-clock watchdog reset request.
// That request also resets every register in the block on the next edge.
// Assumes: rst_n is synchronous and active low.
module wdog_itmr #(
    parameter int CNT_W = wdog_pkg::CNT_W,
    parameter int PRE_W = wdog_pkg::PRE_W,
    parameter int SEL_W = wdog_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_cnt,
    input  logic             host_wr_ctl,
    input  logic             host_rd_ctl,
    input  logic [CNT_W-1:0] host_wdata,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] ctl_q,
    output logic             irq_req,
    output logic             rst_req
);
    localparam int GAP_W = CNT_W - 3 - SEL_W;

    logic             srst_n;
    logic             tick;
    logic             wrap;
    logic             ovf;
    logic             mode;
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             rst_req_q;

    // Combined reset: external reset or the watchdog's own request
    assign srst_n = rst_n & ~rst_req_q;

    wdog_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .srst_n (srst_n),
        .sel    (sel),
        .tick   (tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .srst_n   (srst_n),
        .en       (en),
        .tick     (tick),
        .load     (host_wr_cnt),
        .load_val (host_wdata),
        .cnt      (cnt_q),
        .wrap     (wrap)
    );

    wdog_csr #(.DATA_W(CNT_W), .SEL_W(SEL_W)) u_csr (
        .clk    (clk),
        .srst_n (srst_n),
        .wr     (host_wr_ctl),
        .rd     (host_rd_ctl),
        .wdata  (host_wdata),
        .wrap   (wrap),
        .ovf    (ovf),
        .mode   (mode),
        .en     (en),
        .sel    (sel)
    );

    // Watchdog reset request: raised by a wrap in watchdog mode, self-clearing
    always_ff @(posedge clk) begin
        if (!srst_n) rst_req_q <= 1'b0;
        else         rst_req_q <= wrap & mode;
    end

    assign rst_req = rst_req_q;
    assign irq_req = ovf & ~mode & irq_en;
    assign ctl_q   = {ovf, mode, en, {GAP_W{1'b0}}, sel};
endmodule

// File: rtl/wdog_itmr_chk.sv
// Module: assertion checker for wdog_itmr, attached by bind.
// Observes only the top-level ports.
module wdog_itmr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr_cnt,
    input logic       host_wr_ctl,
    input logic [7:0] host_wdata,
    input logic [7:0] cnt_q,
    input logic [7:0] ctl_q,
    input logic       irq_req,
    input logic       rst_req
);
    // R2: without host writes the counter holds or steps by one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[5] && !host_wr_cnt && !host_wr_ctl) |=>
        (cnt_q == $past(cnt_q) || cnt_q == 8'($past(cnt_q) + 8'd1)));

    // R3: disabled counter sits at zero
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[5] && !host_wr_ctl) |=> (cnt_q == 8'h00));

    // R5: flag only rises from an all-ones count
    p_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[7] && cnt_q != 8'hFF) |=> !ctl_q[7]);

    // R7: disabling write clears the flag
    p_disable_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_ctl && !host_wdata[5]) |=> !ctl_q[7]);

    // R8: no interrupt request in watchdog mode
    p_irq_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[6] |-> !irq_req);

    // R9: reset request lasts one clock
    p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9: registers are back at reset values after the request
    p_wdog_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (ctl_q == 8'h00 && cnt_q == 8'h00));
endmodule

bind wdog_itmr wdog_itmr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr_cnt (host_wr_cnt),
    .host_wr_ctl (host_wr_ctl),
    .host_wdata  (host_wdata),
    .cnt_q       (cnt_q),
    .ctl_q       (ctl_q),
    .irq_req     (irq_req),
    .rst_req     (rst_req)
);

// File: tb/wdog_itmr_tb.sv
// Bench for wdog_itmr: a table of divisor windows, then directed tests.
module wdog_itmr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_cnt = 1'b0;
    logic       host_wr_ctl = 1'b0;
    logic       host_rd_ctl = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       irq_en = 1'b0;
    logic [7:0] cnt_q;
    logic [7:0] ctl_q;
    logic       irq_req;
    logic       rst_req;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Divisor window table: {select, window cycles, expected advance}
    localparam int NVEC = 7;
    localparam int VEC [NVEC][3] = '{
        '{0, 16, 8}, '{1, 256, 4}, '{2, 256, 2}, '{3, 1024, 2},
        '{4, 4096, 2}, '{5, 8192, 1}, '{6, 32768, 1}};

    always #2 clk = ~clk;   // 250 MHz

    wdog_itmr u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr_cnt(host_wr_cnt),
        .host_wr_ctl(host_wr_ctl), .host_rd_ctl(host_rd_ctl),
        .host_wdata(host_wdata), .irq_en(irq_en), .cnt_q(cnt_q),
        .ctl_q(ctl_q), .irq_req(irq_req), .rst_req(rst_req));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk); host_wr_ctl = 1'b1; host_wdata = d;
        @(negedge clk); host_wr_ctl = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] d);
        @(negedge clk); host_wr_cnt = 1'b1; host_wdata = d;
        @(negedge clk); host_wr_cnt = 1'b0;
    endtask

    task automatic rd_ctl();
        @(negedge clk); host_rd_ctl = 1'b1;
        @(negedge clk); host_rd_ctl = 1'b0;
    endtask

    // Watchdog on the bench itself
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
            finish_run();
        end
    end

    initial begin
        logic [7:0] s0;
        logic [7:0] s1;
        bit seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cnt_q == 8'h00, "R1 cnt", cnt_q, 0);
        check(ctl_q == 8'h00, "R1 ctl", ctl_q, 0);
        check(!irq_req && !rst_req, "R1 req", {irq_req, rst_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: field storage, bits 4..3 read as zero
        wr_ctl(8'h3D);
        check(ctl_q == 8'h25, "R10 layout", ctl_q, 8'h25);
        wr_ctl(8'h00);

        // R3: disabled counter ignores writes and ticks
        wr_cnt(8'h55);
        check(cnt_q == 8'h00, "R3 write ignored", cnt_q, 0);
        repeat (20) @(negedge clk);
        check(cnt_q == 8'h00, "R3 held", cnt_q, 0);

        // R2: table walk over divisor windows
        for (int i = 0; i < NVEC; i++) begin
            wr_ctl(8'h20 | 8'(VEC[i][0]));
            s0 = cnt_q;
            repeat (VEC[i][1]) @(negedge clk);
            s1 = cnt_q;
            check(8'(s1 - s0) == 8'(VEC[i][2]), $sformatf("R2 sel %0d", VEC[i][0]),
                  8'(s1 - s0), VEC[i][2]);
        end
        // R2: slowest tap advances at most once in half its period
        wr_ctl(8'h27);
        s0 = cnt_q;
        repeat (65536) @(negedge clk);
        s1 = cnt_q;
        check(8'(s1 - s0) <= 8'd1, "R2 sel 7", 8'(s1 - s0), 1);

        // R4: load while enabled
        wr_ctl(8'h20);
        wr_cnt(8'hFE);
        check(cnt_q == 8'hFE, "R4 load", cnt_q, 8'hFE);
        // R5: wrap sets the flag
        repeat (8) @(negedge clk);
        check(ctl_q[7] == 1'b1, "R5 flag set", ctl_q, 8'hA0);

        // R8: interrupt follows flag and enable
        irq_en = 1'b1; #1;
        check(irq_req == 1'b1, "R8 irq on", irq_req, 1);
        irq_en = 1'b0; #1;
        check(irq_req == 1'b0, "R8 irq masked", irq_req, 0);

        // R6: write 0 without a prior read leaves the flag
        wr_ctl(8'h20);
        check(ctl_q[7] == 1'b1, "R6 no read", ctl_q, 8'hA0);
        rd_ctl();
        wr_ctl(8'hA0);
        check(ctl_q[7] == 1'b1, "R6 write one", ctl_q, 8'hA0);
        wr_ctl(8'h20);
        check(ctl_q[7] == 1'b0, "R6 cleared", ctl_q, 8'h20);
        wr_ctl(8'hA0);
        check(ctl_q[7] == 1'b0, "R6 no set", ctl_q, 8'h20);

        // R7: disable clears flag without a read
        wr_cnt(8'hFE);
        repeat (8) @(negedge clk);
        check(ctl_q[7] == 1'b1, "R7 flag pre", ctl_q, 8'hA0);
        wr_ctl(8'h00);
        @(negedge clk);
        check(ctl_q == 8'h00 && cnt_q == 8'h00, "R7 cleared", {ctl_q, cnt_q}, 0);

        // R9: watchdog reset pulse
        irq_en = 1'b1;
        wr_ctl(8'h60);
        wr_cnt(8'hFD);
        seen = 1'b0;
        for (int k = 0; k < 20 && !seen; k++) begin
            @(negedge clk);
            if (rst_req) begin
                seen = 1'b1;
                check(ctl_q[7] && ctl_q[6], "R9 flag in pulse", ctl_q, 8'hE0);
                check(!irq_req, "R8 no irq in watchdog", irq_req, 0);
                @(negedge clk);
                check(!rst_req, "R9 one clock", rst_req, 0);
                check(ctl_q == 8'h00 && cnt_q == 8'h00, "R9 self reset", {ctl_q, cnt_q}, 0);
            end
        end
        check(seen, "R9 pulse seen", seen, 1);

        // R1: external reset mid-run
        wr_ctl(8'h20);
        wr_cnt(8'h40);
        rst_n = 1'b0;
        @(negedge clk);
        check(cnt_q == 8'h00 && ctl_q == 8'h00, "R1 rerun", {ctl_q, cnt_q}, 0);
        finish_run();
    end
endmodule